// File: doc/BRIEF.md
# Host-Bus Parallel Port Latch

This block holds an 8-bit latch that serves two roles. In its everyday role it is an output port. The local core loads the latch one nibble or one whole byte at a time. A drive-enable bit then chooses one of two pin states: the latch contents appear on the pins, or the pins float so they can be read as inputs. The core can sample the pin levels at any moment, whatever state the drivers are in.

When the mode strap is held low, the same latch becomes a mailbox that an external host writes. Three general-purpose inputs take over the host roles:

- bit 1 is the read strobe;
- bit 2 is the chip select;
- bit 3 is the write strobe.

All three are active low. Each passes through a two-stage synchroniser before any edge is detected. When the write strobe rises while chip select is low, the latch captures the pin levels. A ready line on general output bit 0 then tells the host that the local core has not yet consumed the value.

Top module: `hbport_latch`

## Requirements
- R1: After reset the latch is 0x00, `pad_oe` is 0 and the ready flag is 0, so `gout0` reads 0 in host-bus mode.
- R2: A pulse on `loc_ld_byte` loads `loc_byte` into the latch. `loc_ld_lo` replaces bits [3:0] with `loc_nib` and `loc_ld_hi` replaces bits [7:4` with `loc_nib`; each nibble load keeps the other nibble. A byte load takes priority over a nibble load in the same cycle. The new value shows on `pad_out` after the clock edge.
- R3: `pad_out` always carries the latch value. `drv_wr` writes `drv_val` into the drive-enable bit, and `pad_oe` follows that bit whenever no host read is active.
- R4: `loc_rd_data` equals `pad_in` at all times, whether the drivers are on or off.
- R5: In host-bus mode (`mode_n` = 0), a rising edge on `gp_in[3]` while `gp_in[2]` is low captures `pad_in` into the latch. The capture happens on the third clock edge after the strobe rises.
- R6: A write-strobe edge has no effect on the latch or the ready flag in either of two cases: `gp_in[2]` is high, or `mode_n` is 1.
- R7: A host capture sets the ready flag. A `loc_rd` pulse or any local load clears it. If a capture and a clear fall in the same cycle, the capture wins.
- R8: When `mode_n` is 1, `gout0` equals `gout0_loc`. When `mode_n` is 0, `gout0` shows the ready flag.
- R9: In host-bus mode, holding `gp_in[1]` and `gp_in[2]` both low turns `pad_oe` on within three clock edges, even when the drive-enable bit is 0. The host read ends once either strobe goes high again, and after that `pad_oe` returns to the drive-enable bit.
- R10: A host capture in the same cycle as a local load wins; the latch takes the pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_ld_lo | input | 1 | Load `loc_nib` into latch bits [3:0] |
| loc_ld_hi | input | 1 | Load `loc_nib` into latch bits [7:4] |
| loc_nib | input | 4 | Nibble data from the local core |
| loc_ld_byte | input | 1 | Load `loc_byte` into the whole latch |
| loc_byte | input | 8 | Byte data, from memory or a constant |
| loc_rd | input | 1 | Local core consumes the latch; clears ready |
| loc_rd_data | output | 8 | Current pin levels |
| drv_wr | input | 1 | Write strobe for the drive-enable bit |
| drv_val | input | 1 | New value of the drive-enable bit |
| mode_n | input | 1 | Mode strap; low selects host-bus mode |
| gp_in | input | 3 | General inputs 3..1: write strobe, chip select, read strobe |
| gout0_loc | input | 1 | Value of general output 0 outside host-bus mode |
| gout0 | output | 1 | General output 0 (ready line in host-bus mode) |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pin output values (latch) |
| pad_oe | output | 1 | Pin output enable |

## Verification
The assertions take three things as given:

- `mode_n` is a strap that changes only while all three strobes are idle.
- Pin data stays steady from the fall of the write strobe until the synchronised rising edge has been captured.
- Chip select stays low through that window.

The stimulus keeps to these rules because every host cycle comes from a single task. That task holds `pad_in` and chip select for four clocks after the write strobe rises and only then releases chip select. Local operations, mode changes and drive-enable writes are issued only between host cycles. The single exception is a directed case that deliberately lines a local load up with the capture edge.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    // bit positions in the synchronised strobe vector (gp_in[3:1] -> [2:0])
    localparam int STB_RD = 0;
    localparam int STB_CS = 1;
    localparam int STB_WR = 2;
    localparam int STB_W  = 3;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_HOST  = 2'd2
    } hbp_src_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic RST_BIT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = STAGES * W;

    logic [CW-1:0]   chain_q;
    logic [CW+W-1:0] chain_ext;

    assign chain_ext = {chain_q, d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CW{RST_BIT}};
        else        chain_q <= chain_ext[CW-1:0];
    end

    assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/hbp_edge.sv
module hbp_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/hbp_padctl.sv
module hbp_padctl (
    input  logic host_mode,
    input  logic drv_q,
    input  logic rd_s,
    input  logic cs_s,
    input  logic rdy_q,
    input  logic gout0_loc,
    output logic pad_oe,
    output logic gout0
);
    logic host_rd;

    assign host_rd = host_mode & ~rd_s & ~cs_s;
    assign pad_oe  = drv_q | host_rd;
    assign gout0   = host_mode ? rdy_q : gout0_loc;
endmodule

// File: rtl/hbport_latch.sv
module hbport_latch
    import hbp_pkg::*;
#(
    parameter int LATCH_W     = 8,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_ld_lo,
    input  logic               loc_ld_hi,
    input  logic [NIB_W-1:0]   loc_nib,
    input  logic               loc_ld_byte,
    input  logic [LATCH_W-1:0] loc_byte,
    input  logic               loc_rd,
    output logic [LATCH_W-1:0] loc_rd_data,
    input  logic               drv_wr,
    input  logic               drv_val,
    input  logic               mode_n,
    input  logic [3:1]         gp_in,
    input  logic               gout0_loc,
    output logic               gout0,
    input  logic [LATCH_W-1:0] pad_in,
    output logic [LATCH_W-1:0] pad_out,
    output logic               pad_oe
);
    localparam int HI_LSB = LATCH_W - NIB_W;

    typedef struct packed {
        logic [LATCH_W-1:0] latch;
        logic               drv;
        logic               rdy;
    } st_t;

    st_t st_d, st_q;

    logic [STB_W-1:0] stb_raw, stb_s;
    logic             wr_rise;
    logic             host_mode;
    logic             wr_fire;
    logic             loc_ld_any;
    hbp_src_e         src;

    // signals observed by the bound checker
    logic [LATCH_W-1:0] latch_q;
    logic               rdy_q;
    logic               drv_q;

    assign stb_raw   = gp_in[3:1];
    assign host_mode = ~mode_n;

    hbp_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stb_raw),
        .q     (stb_s)
    );

    hbp_edge #(.W(1)) u_wr_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb_s[STB_WR]),
        .rise  (wr_rise)
    );

    assign wr_fire    = host_mode & wr_rise & ~stb_s[STB_CS];
    assign loc_ld_any = loc_ld_byte | loc_ld_lo | loc_ld_hi;

    always_comb begin
        st_d = st_q;

        if (wr_fire)         src = SRC_HOST;
        else if (loc_ld_any) src = SRC_LOCAL;
        else                 src = SRC_HOLD;

        case (src)
            SRC_HOST:  st_d.latch = pad_in;
            SRC_LOCAL: begin
                if (loc_ld_byte) begin
                    st_d.latch = loc_byte;
                end else begin
                    if (loc_ld_lo) st_d.latch[NIB_W-1:0]      = loc_nib;
                    if (loc_ld_hi) st_d.latch[LATCH_W-1:HI_LSB] = loc_nib;
                end
            end
            default: ;
        endcase

        if (drv_wr) st_d.drv = drv_val;

        if (wr_fire)                   st_d.rdy = 1'b1;
        else if (loc_rd || loc_ld_any) st_d.rdy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q     = st_q.latch;
    assign rdy_q       = st_q.rdy;
    assign drv_q       = st_q.drv;
    assign pad_out     = st_q.latch;
    assign loc_rd_data = pad_in;

    hbp_padctl u_padctl (
        .host_mode (host_mode),
        .drv_q     (st_q.drv),
        .rd_s      (stb_s[STB_RD]),
        .cs_s      (stb_s[STB_CS]),
        .rdy_q     (st_q.rdy),
        .gout0_loc (gout0_loc),
        .pad_oe    (pad_oe),
        .gout0     (gout0)
    );
endmodule

// File: rtl/hbp_latch_chk.sv
module hbp_latch_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] latch_q,
    input logic         rdy_q,
    input logic         drv_q,
    input logic         wr_fire,
    input logic [W-1:0] pad_in,
    input logic         pad_oe,
    input logic         mode_n,
    input logic         loc_ld_any,
    input logic         loc_ld_byte,
    input logic [W-1:0] loc_byte,
    input logic         loc_rd
);
    // R2
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ld_byte && !wr_fire) |=> (latch_q == $past(loc_byte)));

    // R5
    host_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (latch_q == $past(pad_in)) && rdy_q);

    // R6
    normal_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_n && !loc_ld_any) |=> $stable(latch_q));

    // R7
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((loc_rd || loc_ld_any) && !wr_fire) |=> !rdy_q);

    // R7
    rdy_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(wr_fire));

    // R3
    oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (drv_q || !mode_n));
endmodule

bind hbport_latch hbp_latch_chk #(.W(LATCH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_q     (latch_q),
    .rdy_q       (rdy_q),
    .drv_q       (drv_q),
    .wr_fire     (wr_fire),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .mode_n      (mode_n),
    .loc_ld_any  (loc_ld_any),
    .loc_ld_byte (loc_ld_byte),
    .loc_byte    (loc_byte),
    .loc_rd      (loc_rd)
);

// File: tb/sim_hbport_latch.sv
module sim_hbport_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_ld_lo = 1'b0, loc_ld_hi = 1'b0, loc_ld_byte = 1'b0, loc_rd = 1'b0;
    logic [3:0] loc_nib = '0;
    logic [7:0] loc_byte = '0;
    logic [7:0] loc_rd_data;
    logic       drv_wr = 1'b0, drv_val = 1'b0;
    logic       mode_n = 1'b0;
    logic [3:1] gp_in = 3'b111;
    logic       gout0_loc = 1'b0;
    logic       gout0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic       pad_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [7:0] exp_latch = '0;
    logic       exp_rdy   = 1'b0;
    logic       exp_drv   = 1'b0;

    always #5 clk = ~clk;

    hbport_latch u0 (
        .clk(clk), .rst_n(rst_n),
        .loc_ld_lo(loc_ld_lo), .loc_ld_hi(loc_ld_hi), .loc_nib(loc_nib),
        .loc_ld_byte(loc_ld_byte), .loc_byte(loc_byte),
        .loc_rd(loc_rd), .loc_rd_data(loc_rd_data),
        .drv_wr(drv_wr), .drv_val(drv_val),
        .mode_n(mode_n), .gp_in(gp_in),
        .gout0_loc(gout0_loc), .gout0(gout0),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] f_lo(input logic [7:0] old, input logic [3:0] n);
        return {old[7:4], n};
    endfunction

    function automatic logic [7:0] f_hi(input logic [7:0] old, input logic [3:0] n);
        return {n, old[3:0]};
    endfunction

    function automatic logic f_gout(input logic mn, input logic rdy, input logic loc);
        return mn ? loc : rdy;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(pad_out == exp_latch, req, pad_out, exp_latch);
        chk(pad_oe == exp_drv, {req, " oe"}, {7'd0, pad_oe}, {7'd0, exp_drv});
        chk(gout0 == f_gout(mode_n, exp_rdy, gout0_loc), {req, " gout0 R8"},
            {7'd0, gout0}, {7'd0, f_gout(mode_n, exp_rdy, gout0_loc)});
    endtask

    task automatic do_byte(input logic [7:0] v);
        @(negedge clk); loc_byte = v; loc_ld_byte = 1'b1;
        @(negedge clk); loc_ld_byte = 1'b0;
        exp_latch = v; exp_rdy = 1'b0;
    endtask

    task automatic do_nib(input bit hi, input logic [3:0] n);
        @(negedge clk); loc_nib = n; loc_ld_lo = !hi; loc_ld_hi = hi;
        @(negedge clk); loc_ld_lo = 1'b0; loc_ld_hi = 1'b0;
        exp_latch = hi ? f_hi(exp_latch, n) : f_lo(exp_latch, n);
        exp_rdy = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk); loc_rd = 1'b1;
        @(negedge clk); loc_rd = 1'b0;
        exp_rdy = 1'b0;
    endtask

    task automatic do_drv(input logic v);
        @(negedge clk); drv_wr = 1'b1; drv_val = v;
        @(negedge clk); drv_wr = 1'b0;
        exp_drv = v;
    endtask

    // host write cycle; gp_in = {wr, cs, rd}
    task automatic host_wr(input logic [7:0] d, input bit cs_low);
        @(negedge clk); pad_in = d; gp_in = {1'b0, !cs_low, 1'b1};
        repeat (3) @(negedge clk);
        gp_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        gp_in = 3'b111;
        repeat (3) @(negedge clk);
        if (!mode_n && cs_low) begin
            exp_latch = d; exp_rdy = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'h1c0d_5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pad_out == 8'h00, "R1 latch", pad_out, 8'h00);
        chk(pad_oe == 1'b0, "R1 oe", {7'd0, pad_oe}, 8'h00);
        chk(gout0 == 1'b0, "R1 ready", {7'd0, gout0}, 8'h00);

        // R2 directed: byte, nibbles, byte beats nibble
        do_byte(8'hA5); chk_state("R2 byte");
        do_nib(1'b0, 4'h3); chk_state("R2 lo nibble");
        do_nib(1'b1, 4'hC); chk_state("R2 hi nibble");
        @(negedge clk); loc_byte = 8'h5A; loc_ld_byte = 1'b1; loc_ld_lo = 1'b1; loc_nib = 4'hF;
        @(negedge clk); loc_ld_byte = 1'b0; loc_ld_lo = 1'b0;
        exp_latch = 8'h5A;
        chk_state("R2 byte priority");

        // R3 / R4: drivers and pin readback
        do_drv(1'b1); chk_state("R3 drive on");
        pad_in = 8'h3C; #1;
        chk(loc_rd_data == 8'h3C, "R4 readback driven", loc_rd_data, 8'h3C);
        do_drv(1'b0); chk_state("R3 drive off");
        pad_in = 8'hC3; #1;
        chk(loc_rd_data == 8'hC3, "R4 readback float", loc_rd_data, 8'hC3);

        // R5 host write, R7 ready set
        host_wr(8'h96, 1'b1); chk_state("R5 host capture");
        do_rd(); chk_state("R7 ready cleared by read");
        // R6 chip select high, and normal mode
        host_wr(8'h11, 1'b0); chk_state("R6 cs high ignored");
        mode_n = 1'b1; gout0_loc = 1'b1;
        host_wr(8'h22, 1'b1); chk_state("R6 normal mode ignored");
        gout0_loc = 1'b0; #1; chk_state("R8 local gout0");
        mode_n = 1'b0;

        // R9 host read drives pins
        @(negedge clk); gp_in = 3'b100;
        repeat (3) @(negedge clk);
        chk(pad_oe == 1'b1, "R9 host read oe", {7'd0, pad_oe}, 8'h01);
        gp_in = 3'b111;
        repeat (3) @(negedge clk);
        chk(pad_oe == 1'b0, "R9 host read release", {7'd0, pad_oe}, 8'h00);

        // R10 / R7 capture and local load in the same cycle
        @(negedge clk); pad_in = 8'hE7; gp_in = 3'b001;
        repeat (3) @(negedge clk);
        gp_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        loc_byte = 8'h18; loc_ld_byte = 1'b1; loc_rd = 1'b1;
        @(negedge clk); loc_ld_byte = 1'b0; loc_rd = 1'b0;
        repeat (3) @(negedge clk);
        gp_in = 3'b111;
        repeat (2) @(negedge clk);
        exp_latch = 8'hE7; exp_rdy = 1'b1;
        chk_state("R10 host beats local, R7 set wins");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 7));
            gout0_loc = 1'($urandom);
            case (op)
                0: do_byte(8'($urandom));
                1: do_nib(1'b0, 4'($urandom));
                2: do_nib(1'b1, 4'($urandom));
                3: do_rd();
                4: do_drv(1'($urandom));
                5: host_wr(8'($urandom), ($urandom_range(0, 3) != 0));
                6: mode_n = ($urandom_range(0, 3) == 0);
                default: begin
                    logic [7:0] p;
                    p = 8'($urandom);
                    @(negedge clk); pad_in = p; #1;
                    chk(loc_rd_data == p, "R4 random readback", loc_rd_data, p);
                end
            endcase
            #1;
            chk_state("R2 R5 R6 R7 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule